// File: doc/BRIEF.md
# Fuse Array Access Sequencer

This block sits between a register interface and a one-time-programmable fuse macro and runs every access to the macro as a series of timed phases. A command picks one of three operations. A single-word read returns one word of the array. A single-bit program burns one bit. A bulk sense reads every word of the array and fills a bank of shadow cache registers that the rest of the chip can read at any time without waking the macro.

Each phase holds the macro control lines steady for a number of clock cycles that software supplies through a packed timing vector, one slot per phase. Commands enter through a valid/ready handshake. A read result leaves through a valid/ready handshake as well. Software can poll the current phase code, a sense-complete flag and the power-down line to follow progress.

Back-pressure rules: a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the sequencer is idle and no read result is waiting. A read result stays on `rsp_data`, with `rsp_valid` high, until an edge where `rsp_ready` is also high. While it waits, no new command is accepted.

Top module: `fuse_seq_ctrl`

## Requirements
- R1: After reset the phase code is 0 (idle), `cmd_ready` is 1, `rsp_valid` is 0, `sense_done` is 0 and every cache word reads 0.
- R2: Operation codes are 1 = read, 2 = program and 3 = sense. A command with code 0 is taken by the handshake but leaves the sequencer idle. A command presented while an operation is running is not taken and does not change that operation.
- R3: Phase codes are 1 power-up, 2 read setup, 3 sample, 4 read strobe, 5 read hold, 6 read-before-write setup, 7 program setup, 8 address setup, 9 source setup, 10 program strobe, 11 source hold and 12 address hold. Phase p lasts L cycles, where L is the value in bits [(p-1)*TW +: TW] of `phase_len`. An L of 0 is treated as 1.
- R4: A read visits phases 1, 2, 3, 4, 5 and then returns to idle. `mac_rd_strobe` is high exactly during phase 4. The value on `mac_rdata` in the last cycle of phase 4 becomes the result on `rsp_data`.
- R5: A program operation visits phases 1, 6, 7, 8, 9, 10, 11, 12 and then returns to idle. `mac_pgm_strobe` is high exactly during phase 10. `mac_src_en` is high exactly during phases 9 to 11. The command's word address and bit index stay on `mac_addr` and `mac_bit` throughout.
- R6: A sense visits phase 1 once. It then runs phases 2 to 5 once for each word address, in ascending order from 0, and writes each sampled word into the cache entry with the same index. `sense_done` is cleared when a sense is taken and set when the sequencer returns to idle after the last word.
- R7: A read result is held stable with `rsp_valid` high until it is taken. While it waits, `cmd_ready` stays low.
- R8: `mac_pd` follows `pd_req` while idle and is 0 in every other phase.
- R9: `mac_margin` is high during phases 2 to 5 of a read or sense whose `margin_req` was high when the command was taken. It is low at all other times.
- R10: `mac_sel` is high in every phase except idle and power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 2 | Operation code |
| cmd_addr | input | AW | Word address for read or program |
| cmd_bit | input | BW | Bit index for program |
| pd_req | input | 1 | Request macro power-down while idle |
| margin_req | input | 1 | Use the margin trip point for reads |
| phase_len | input | 12*TW | Packed per-phase durations |
| rsp_valid | output | 1 | Read result available |
| rsp_ready | input | 1 | Read result taken |
| rsp_data | output | DW | Read result |
| state | output | 4 | Current phase code |
| sense_done | output | 1 | Bulk sense finished |
| cache_idx | input | AW | Cache word select |
| cache_data | output | DW | Selected cache word |
| mac_pd | output | 1 | Macro power-down |
| mac_sel | output | 1 | Macro select |
| mac_addr | output | AW | Macro word address |
| mac_bit | output | BW | Macro bit index for programming |
| mac_rd_strobe | output | 1 | Macro read strobe |
| mac_pgm_strobe | output | 1 | Macro program strobe |
| mac_src_en | output | 1 | Macro programming source enable |
| mac_margin | output | 1 | Macro margin-read select |
| mac_rdata | input | DW | Macro read data |

## Verification
The hardest situation to reach is a finished read whose result is held back. In that case a new command is already on the bus and must wait even though the phase code shows idle. The stimulus reaches it by lowering `rsp_ready` before a read and then offering a program command during the wait.

A second hard case is a command held on the bus for the whole of an operation, with its code changed after acceptance. The stimulus holds such a command and then confirms that the phase trace matches a plain read.

Random per-phase durations include 0. This exercises the one-cycle floor in every phase. A bench model of the macro burns bits so that later reads and senses show the effect of each program operation.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

  localparam int NUM_PHASES = 12;

  typedef enum logic [3:0] {
    PH_IDLE        = 4'd0,
    PH_PWR_UP      = 4'd1,
    PH_RD_SU       = 4'd2,
    PH_RD_SMP      = 4'd3,
    PH_RD_STB      = 4'd4,
    PH_RD_HLD      = 4'd5,
    PH_RBW_SU      = 4'd6,
    PH_WR_SU       = 4'd7,
    PH_WR_ADDR_SU  = 4'd8,
    PH_SRC_SU      = 4'd9,
    PH_WR_PGM      = 4'd10,
    PH_SRC_HLD     = 4'd11,
    PH_WR_ADDR_HLD = 4'd12
  } phase_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_PROG  = 2'd2,
    OP_SENSE = 2'd3
  } op_e;

endpackage

// File: rtl/fuse_phase_timer.sv
module fuse_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_len,
  output logic          expire
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= TW'(1);
    end else if (load) begin
      cnt <= (load_len == '0) ? TW'(1) : load_len;
    end else if (cnt > TW'(1)) begin
      cnt <= cnt - TW'(1);
    end
  end

  assign expire = (cnt == TW'(1));

  // R3: a running count falls by exactly one per cycle
  a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt > TW'(1)) |=> (cnt == $past(cnt) - TW'(1)));

endmodule

// File: rtl/fuse_cache_bank.sv
module fuse_cache_bank #(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ridx,
  output logic [DW-1:0] rdata
);

  localparam int WORDS = 1 << AW;

  logic [DW-1:0] words_q [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words_q[i] <= '0;
      end else if (we && widx == AW'(i)) begin
        words_q[i] <= wdata;
      end
    end
  end

  assign rdata = words_q[ridx];

endmodule

// File: rtl/fuse_macro_drive.sv
module fuse_macro_drive
  import fuse_seq_pkg::*;
(
  input  phase_e phase,
  input  logic   pd_req,
  input  logic   margin_en,
  output logic   mac_pd,
  output logic   mac_sel,
  output logic   mac_rd_strobe,
  output logic   mac_pgm_strobe,
  output logic   mac_src_en,
  output logic   mac_margin
);

  always_comb begin
    mac_pd         = (phase == PH_IDLE) && pd_req;
    mac_sel        = (phase != PH_IDLE) && (phase != PH_PWR_UP);
    mac_rd_strobe  = (phase == PH_RD_STB);
    mac_pgm_strobe = (phase == PH_WR_PGM);
    mac_src_en     = (phase == PH_SRC_SU) || (phase == PH_WR_PGM) ||
                     (phase == PH_SRC_HLD);
    mac_margin     = margin_en &&
                     ((phase == PH_RD_SU) || (phase == PH_RD_SMP) ||
                      (phase == PH_RD_STB) || (phase == PH_RD_HLD));
  end

endmodule

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
  import fuse_seq_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 32,
  parameter int TW = 8,
  parameter int BW = $clog2(DW)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [1:0]             cmd_op,
  input  logic [AW-1:0]          cmd_addr,
  input  logic [BW-1:0]          cmd_bit,
  input  logic                   pd_req,
  input  logic                   margin_req,
  input  logic [NUM_PHASES*TW-1:0] phase_len,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [DW-1:0]          rsp_data,
  output logic [3:0]             state,
  output logic                   sense_done,
  input  logic [AW-1:0]          cache_idx,
  output logic [DW-1:0]          cache_data,
  output logic                   mac_pd,
  output logic                   mac_sel,
  output logic [AW-1:0]          mac_addr,
  output logic [BW-1:0]          mac_bit,
  output logic                   mac_rd_strobe,
  output logic                   mac_pgm_strobe,
  output logic                   mac_src_en,
  output logic                   mac_margin,
  input  logic [DW-1:0]          mac_rdata
);

  localparam int WORDS = 1 << AW;

  phase_e        phase_q, phase_d, succ;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] bit_q;
  logic          margin_q;
  logic          accept, expire, tmr_load, capture, last_word;
  logic [TW-1:0] tmr_len;

  assign cmd_ready = (phase_q == PH_IDLE) && !rsp_valid;
  assign accept    = cmd_valid && cmd_ready && (op_e'(cmd_op) != OP_NONE);
  assign last_word = (addr_q == AW'(WORDS - 1));
  assign capture   = (phase_q == PH_RD_STB) && expire;

  always_comb begin
    unique case (phase_q)
      PH_PWR_UP:      succ = (op_q == OP_PROG) ? PH_RBW_SU : PH_RD_SU;
      PH_RD_SU:       succ = PH_RD_SMP;
      PH_RD_SMP:      succ = PH_RD_STB;
      PH_RD_STB:      succ = PH_RD_HLD;
      PH_RD_HLD:      succ = (op_q == OP_SENSE && !last_word) ? PH_RD_SU : PH_IDLE;
      PH_RBW_SU:      succ = PH_WR_SU;
      PH_WR_SU:       succ = PH_WR_ADDR_SU;
      PH_WR_ADDR_SU:  succ = PH_SRC_SU;
      PH_SRC_SU:      succ = PH_WR_PGM;
      PH_WR_PGM:      succ = PH_SRC_HLD;
      PH_SRC_HLD:     succ = PH_WR_ADDR_HLD;
      default:        succ = PH_IDLE;
    endcase
  end

  always_comb begin
    int idx;
    if (phase_q == PH_IDLE) phase_d = accept ? PH_PWR_UP : PH_IDLE;
    else                    phase_d = expire ? succ : phase_q;
    tmr_load = (phase_d != phase_q) && (phase_d != PH_IDLE);
    idx      = (phase_d == PH_IDLE) ? 0 : int'(phase_d) - 1;
    tmr_len  = phase_len[idx*TW +: TW];
  end

  fuse_phase_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_len (tmr_len),
    .expire   (expire)
  );

  fuse_cache_bank #(.AW(AW), .DW(DW)) u_cache (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (capture && op_q == OP_SENSE),
    .widx  (addr_q),
    .wdata (mac_rdata),
    .ridx  (cache_idx),
    .rdata (cache_data)
  );

  fuse_macro_drive u_drive (
    .phase          (phase_q),
    .pd_req         (pd_req),
    .margin_en      (margin_q),
    .mac_pd         (mac_pd),
    .mac_sel        (mac_sel),
    .mac_rd_strobe  (mac_rd_strobe),
    .mac_pgm_strobe (mac_pgm_strobe),
    .mac_src_en     (mac_src_en),
    .mac_margin     (mac_margin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      op_q       <= OP_NONE;
      addr_q     <= '0;
      bit_q      <= '0;
      margin_q   <= 1'b0;
      sense_done <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
    end else begin
      phase_q <= phase_d;
      if (accept) begin
        op_q     <= op_e'(cmd_op);
        addr_q   <= (op_e'(cmd_op) == OP_SENSE) ? '0 : cmd_addr;
        bit_q    <= cmd_bit;
        margin_q <= margin_req && (op_e'(cmd_op) != OP_PROG);
        if (op_e'(cmd_op) == OP_SENSE) sense_done <= 1'b0;
      end
      if (phase_q == PH_RD_HLD && expire && op_q == OP_SENSE) begin
        if (last_word) sense_done <= 1'b1;
        else           addr_q     <= addr_q + AW'(1);
      end
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (capture && op_q == OP_READ) begin
        rsp_valid <= 1'b1;
        rsp_data  <= mac_rdata;
      end
    end
  end

  assign state    = phase_q;
  assign mac_addr = addr_q;
  assign mac_bit  = bit_q;

  // R7: a waiting result keeps its value until taken
  a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R5: the program strobe is always inside the source window
  a_r5_pgm_in_src: assert property (@(posedge clk) disable iff (!rst_n)
    mac_pgm_strobe |-> mac_src_en);

  // R4: a read strobe begins only after the sample phase
  a_r4_strobe_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mac_rd_strobe) |-> ($past(phase_q) == PH_RD_SMP));

  // R6: completion of a sense is flagged only as the sequencer goes idle
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sense_done) |-> (phase_q == PH_IDLE));

  // R8: the macro is never powered down during an operation
  a_r8_pd_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    mac_pd |-> (state == 4'd0));

  // R5: the programmed location stays fixed while programming
  a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_src_en && $past(mac_src_en)) |-> ($stable(mac_addr) && $stable(mac_bit)));

endmodule

// File: tb/fuse_seq_ctrl_test.sv
module fuse_seq_ctrl_test;
  localparam int AW = 3, DW = 32, TW = 8, BW = 5, WORDS = 8, NPH = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_ready, pd_req = 0, margin_req = 0, rsp_valid, rsp_ready = 1;
  logic [1:0] cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0, cache_idx = 0, mac_addr;
  logic [BW-1:0] cmd_bit = 0, mac_bit;
  logic [NPH*TW-1:0] phase_len = '0;
  logic [DW-1:0] rsp_data, cache_data, mac_rdata;
  logic [3:0] state;
  logic sense_done, mac_pd, mac_sel, mac_rd_strobe, mac_pgm_strobe, mac_src_en, mac_margin;

  logic [DW-1:0] seed_mem [WORDS];
  logic [DW-1:0] fmem [WORDS];
  logic [DW-1:0] ref_mem [WORDS];
  int n_vec = 0, n_bad = 0;

  always #5 clk = ~clk;

  fuse_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_bit(cmd_bit), .pd_req(pd_req),
    .margin_req(margin_req), .phase_len(phase_len), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .state(state), .sense_done(sense_done),
    .cache_idx(cache_idx), .cache_data(cache_data), .mac_pd(mac_pd), .mac_sel(mac_sel),
    .mac_addr(mac_addr), .mac_bit(mac_bit), .mac_rd_strobe(mac_rd_strobe),
    .mac_pgm_strobe(mac_pgm_strobe), .mac_src_en(mac_src_en), .mac_margin(mac_margin),
    .mac_rdata(mac_rdata)
  );

  // fuse macro model: burns a bit while the program strobe is high
  assign mac_rdata = fmem[mac_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) fmem[i] <= seed_mem[i];
    end else if (mac_pgm_strobe) begin
      fmem[mac_addr][mac_bit] <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int plen(input int p);
    int l = int'(phase_len[(p-1)*TW +: TW]);
    return (l == 0) ? 1 : l;
  endfunction

  function automatic int exp_phase(input int op, input int k);
    if (k == 0) return 1;
    if (op == 2) return k + 5;
    return ((k - 1) % 4) + 2;
  endfunction

  function automatic int exp_nph(input int op);
    if (op == 1) return 5;
    if (op == 2) return 8;
    return 1 + 4 * WORDS;
  endfunction

  task automatic set_times(input int maxv);
    for (int p = 1; p <= NPH; p++) phase_len[(p-1)*TW +: TW] = TW'($urandom_range(maxv, 0));
  endtask

  task automatic run_op(input int op, input int a, input int b, input bit marg, input bit hold_cmd);
    int k = 0, prev = -1, busy = 0, nrd = 0, npgm = 0, nsrc = 0, nsel = 0, nmar = 0, npd = 0;
    int exp_busy = 0, exp_mar = 0, exp_rd = 0, guard = 0;
    bit seq_ok = 1, got = 0;
    logic [DW-1:0] gdat = '0;
    string rq;
    rq = (op == 2) ? "R5" : ((op == 3) ? "R6" : "R4");
    if (op == 2) ref_mem[a][b] = 1'b1;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'(op); cmd_addr = AW'(a); cmd_bit = BW'(b); margin_req = marg;
    @(negedge clk);
    if (hold_cmd) cmd_op = 2'd3; else cmd_valid = 0;
    while (state != 4'd0 && guard < 5000) begin
      guard++;
      if (int'(state) != prev) begin
        if (exp_phase(op, k) != int'(state)) seq_ok = 0;
        k++; prev = int'(state);
      end
      busy++;
      nrd  += int'(mac_rd_strobe);  npgm += int'(mac_pgm_strobe);
      nsrc += int'(mac_src_en);     nsel += int'(mac_sel);
      nmar += int'(mac_margin);     npd  += int'(mac_pd);
      if (rsp_valid && rsp_ready) begin got = 1; gdat = rsp_data; end
      if (hold_cmd && state == 4'd5) cmd_valid = 0;
      @(negedge clk);
    end
    cmd_valid = 0;
    for (int j = 0; j < exp_nph(op); j++) begin
      int p = exp_phase(op, j);
      exp_busy += plen(p);
      if (marg && op != 2 && p >= 2 && p <= 5) exp_mar += plen(p);
    end
    exp_rd = (op == 1) ? plen(4) : ((op == 3) ? WORDS * plen(4) : 0);
    chk(seq_ok && k == exp_nph(op), rq, k, exp_nph(op));          // phase order
    chk(busy == exp_busy, "R3", busy, exp_busy);                  // durations
    chk(nrd == exp_rd, "R4", nrd, exp_rd);
    chk(npgm == ((op == 2) ? plen(10) : 0), "R5", npgm, (op == 2) ? plen(10) : 0);
    chk(nsrc == ((op == 2) ? plen(9) + plen(10) + plen(11) : 0), "R5", nsrc,
        (op == 2) ? plen(9) + plen(10) + plen(11) : 0);
    chk(nsel == busy - plen(1), "R10", nsel, busy - plen(1));
    chk(nmar == exp_mar, "R9", nmar, exp_mar);
    chk(npd == 0, "R8", npd, 0);
    if (op == 1 && rsp_ready) chk(got && gdat == ref_mem[a], "R4", gdat, ref_mem[a]);
    if (op == 3) begin
      chk(sense_done == 1'b1, "R6", sense_done, 1);
      for (int i = 0; i < WORDS; i++) begin
        cache_idx = AW'(i); #1;
        chk(cache_data == ref_mem[i], "R6", cache_data, ref_mem[i]);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < WORDS; i++) begin
      seed_mem[i] = $urandom();
      ref_mem[i]  = seed_mem[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(state == 4'd0, "R1", state, 0);
    chk(cmd_ready == 1'b1, "R1", cmd_ready, 1);
    chk(rsp_valid == 1'b0, "R1", rsp_valid, 0);
    chk(sense_done == 1'b0, "R1", sense_done, 0);
    for (int i = 0; i < WORDS; i++) begin
      cache_idx = AW'(i); #1;
      chk(cache_data == '0, "R1", cache_data, 0);
    end
    // R8 power-down follows request while idle
    pd_req = 1; @(negedge clk);
    chk(mac_pd == 1'b1, "R8", mac_pd, 1);
    // R2 code 0 is ignored
    cmd_valid = 1; cmd_op = 2'd0; @(negedge clk); cmd_valid = 0;
    @(negedge clk);
    chk(state == 4'd0 && cmd_ready, "R2", state, 0);
    // directed: all zero durations, then long durations
    phase_len = '0;
    run_op(1, 3, 0, 1, 0);
    run_op(2, 3, 31, 0, 0);
    run_op(1, 3, 0, 0, 0);
    set_times(7);
    run_op(3, 0, 0, 1, 0);
    // R2 command held during a read must not replace it
    set_times(3);
    run_op(1, 5, 0, 0, 1);
    chk(sense_done == 1'b1, "R2", sense_done, 1);
    // R7 back-pressure on the result
    rsp_ready = 0;
    run_op(1, 6, 0, 0, 0);
    chk(rsp_valid && rsp_data == ref_mem[6], "R7", rsp_data, ref_mem[6]);
    cmd_valid = 1; cmd_op = 2'd2; cmd_addr = 3'd1; cmd_bit = 5'd4;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(state == 4'd0 && !cmd_ready && rsp_valid, "R7", state, 0);
    end
    cmd_valid = 0; rsp_ready = 1;
    @(negedge clk);
    chk(!rsp_valid && cmd_ready, "R7", rsp_valid, 0);
    // constrained random
    for (int n = 0; n < 40; n++) begin
      int op;
      op = ($urandom_range(9, 0) == 0) ? 3 : int'($urandom_range(2, 1));
      pd_req = 1'($urandom());
      set_times(3);
      run_op(op, int'($urandom_range(WORDS-1, 0)), int'($urandom_range(DW-1, 0)),
             1'($urandom()), 0);
      @(negedge clk);
      chk(mac_pd == pd_req, "R8", mac_pd, pd_req);
    end
    run_op(3, 0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule